// File: doc/BRIEF.md
# Two-Bit Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It holds a small table of history entries. Low bits of the program counter select one entry, so the table is indexed the same way as a direct-mapped cache with no tag. The fetch stage puts its PC on the lookup port and gets back a taken or not-taken guess in the same cycle. When the branch resolves later in the pipeline, the execute stage sends the branch's PC and its actual direction on the update port. The selected entry then moves to its next state on the following clock edge.

By default each entry is a four-state machine with hysteresis. A strongly held direction survives one contrary outcome and flips only after a second contrary outcome in a row. As a result, the single not-taken exit at the end of each pass through a loop costs one misprediction and not two. A parameter selects a one-bit variant instead, which simply remembers the last outcome. This variant exists so that the two schemes can be compared on the same branch stream.

Top module: `bp_predictor`

## Requirements
- R1: After a synchronous active-high reset, every entry predicts not-taken. In the two-bit scheme the reset state is the weak not-taken state; in the one-bit scheme it is the not-taken state.
- R2: The entry is selected by PC bits [IDX_W+1:2], where IDX_W = log2(ENTRIES). PCs that differ only in bits 1:0 or in bits above IDX_W+1 use the same entry.
- R3: lk_taken is 1 exactly when the entry selected by lk_pc is in one of the two taken states. It reflects lk_pc combinationally, in the same cycle.
- R4: In the two-bit scheme, an outcome that matches a weak state's direction moves the entry to the strong state of that direction. Example: after reset, not-taken followed by taken still predicts not-taken.
- R5: In the two-bit scheme, an outcome that contradicts a weak state moves the entry to the strong state of the opposite direction. Example: after reset, a single taken outcome makes the entry predict taken.
- R6: In the two-bit scheme, a strong state flips its prediction only after two consecutive contrary outcomes. One contrary outcome leaves the predicted direction unchanged.
- R7: When a lookup and an update address the same entry in the same cycle, the lookup returns the old prediction. The new state becomes visible from the next cycle on.
- R8: An update changes only the entry that up_pc selects. All other entries keep their state.
- R9: While up_valid is 0, no entry changes, whatever up_pc and up_taken hold.
- R10: With HIST_BITS = 1, each entry predicts the outcome of the most recent update to that entry.
- R11: Take an inner loop branch that is taken 19 times and then not taken, run inside an outer loop branch that repeats the pattern 10 times (taken 9 times, then not taken). Each branch's first execution is not counted. The two-bit scheme then mispredicts 11 times and the one-bit scheme 20 times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lk_pc | input | PC_W | PC of the instruction being fetched |
| lk_taken | output | 1 | Predicted direction for lk_pc (1 = taken) |
| up_valid | input | 1 | A resolved branch is presented this cycle |
| up_pc | input | PC_W | PC of the resolved branch |
| up_taken | input | 1 | Actual direction of the resolved branch |

## Verification
The prediction is a combinational read of the table, so it is due in the same cycle that lk_pc is applied. An update is due one edge later: it shows on lk_taken from the cycle after the edge that samples it. The bench changes inputs on the falling edge and reads lk_taken 1 ns later. Each check therefore sees the state left by all earlier rising edges and none of the pending update. A bench model of every entry advances only after the check for that cycle has been made. The nested-loop test applies the lookup and the update in the same cycle, so each guess is the one made before that branch's outcome is known.

// File: rtl/bp_pkg.sv
package bp_pkg;

    // Instructions are word aligned, so the lowest PC bits carry no information.
    localparam int unsigned PC_ALIGN_BITS = 2;

    // Four-state hysteresis encoding; the MSB is the predicted direction.
    typedef enum logic [1:0] {
        HS_STRONG_NT = 2'b00,
        HS_WEAK_NT   = 2'b01,
        HS_WEAK_T    = 2'b10,
        HS_STRONG_T  = 2'b11
    } hyst_e;

    // Per-entry update request, decoded from the update port.
    typedef struct packed {
        logic write;
        logic taken;
    } cell_upd_t;

    function automatic logic hyst_dir(input hyst_e s);
        return (s == HS_WEAK_T) || (s == HS_STRONG_T);
    endfunction

    // Weak states jump to the strong state of whichever outcome arrived;
    // strong states decay to their weak twin on a contrary outcome.
    function automatic hyst_e hyst_next(input hyst_e s, input logic taken);
        hyst_e n;
        case (s)
            HS_STRONG_NT: n = taken ? HS_WEAK_NT  : HS_STRONG_NT;
            HS_WEAK_NT:   n = taken ? HS_STRONG_T : HS_STRONG_NT;
            HS_WEAK_T:    n = taken ? HS_STRONG_T : HS_STRONG_NT;
            default:      n = taken ? HS_STRONG_T : HS_WEAK_T;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/bp_index.sv
module bp_index #(
    parameter int unsigned PC_W  = 32,
    parameter int unsigned IDX_W = 4
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx
);
    import bp_pkg::*;

    // Direct-mapped selection: drop alignment bits, keep the next IDX_W bits.
    assign idx = IDX_W'(pc >> PC_ALIGN_BITS);

endmodule

// File: rtl/bp_cell.sv
module bp_cell #(
    parameter int unsigned HIST_BITS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  bp_pkg::cell_upd_t upd,
    output logic              pred
);
    import bp_pkg::*;

    generate
        if (HIST_BITS == 1) begin : g_one_bit
            logic last_q;
            always_ff @(posedge clk) begin
                if (rst)
                    last_q <= 1'b0;
                else if (upd.write)
                    last_q <= upd.taken;
            end
            assign pred = last_q;
        end else begin : g_two_bit
            hyst_e st_q;
            always_ff @(posedge clk) begin
                if (rst)
                    st_q <= HS_WEAK_NT;
                else if (upd.write)
                    st_q <= hyst_next(st_q, upd.taken);
            end
            assign pred = hyst_dir(st_q);
        end
    endgenerate

endmodule

// File: rtl/bp_predictor.sv
module bp_predictor #(
    parameter int unsigned PC_W      = 32,
    parameter int unsigned ENTRIES   = 16,
    parameter int unsigned HIST_BITS = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_taken,
    input  logic            up_valid,
    input  logic [PC_W-1:0] up_pc,
    input  logic            up_taken
);
    import bp_pkg::*;

    localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int unsigned DEPTH = 1 << IDX_W;

    logic [IDX_W-1:0] lk_idx;
    logic [IDX_W-1:0] up_idx;
    logic [DEPTH-1:0] pred_vec;

    bp_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_lk_index (
        .pc  (lk_pc),
        .idx (lk_idx)
    );

    bp_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_up_index (
        .pc  (up_pc),
        .idx (up_idx)
    );

    generate
        for (genvar e = 0; e < DEPTH; e++) begin : g_entry
            cell_upd_t cell_upd;
            always_comb begin
                cell_upd.write = up_valid && (up_idx == IDX_W'(e));
                cell_upd.taken = up_taken;
            end
            bp_cell #(.HIST_BITS(HIST_BITS)) u_cell (
                .clk  (clk),
                .rst  (rst),
                .upd  (cell_upd),
                .pred (pred_vec[e])
            );
        end
    endgenerate

    // Read of current state: a same-cycle update is not yet visible.
    assign lk_taken = pred_vec[lk_idx];

endmodule

// File: rtl/bp_predictor_chk.sv
module bp_predictor_chk #(
    parameter int unsigned PC_W      = 32,
    parameter int unsigned ENTRIES   = 16,
    parameter int unsigned HIST_BITS = 2
) (
    input logic            clk,
    input logic            rst,
    input logic [PC_W-1:0] lk_pc,
    input logic            lk_taken,
    input logic            up_valid,
    input logic [PC_W-1:0] up_pc,
    input logic            up_taken
);
    localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    function automatic logic same_entry(input logic [PC_W-1:0] a, input logic [PC_W-1:0] b);
        return a[IDX_W+1:2] == b[IDX_W+1:2];
    endfunction

    // Edges since reset release, saturating at 3.
    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)
            since_rst <= 2'd0;
        else if (since_rst != 2'd3)
            since_rst <= since_rst + 2'd1;
    end

    // R1
    reset_not_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd0) |-> !lk_taken);

    // R4
    two_taken_predicts_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2) && $past(up_valid && up_taken, 2) && $past(up_valid && up_taken)
        && same_entry($past(up_pc, 2), $past(up_pc)) && same_entry(lk_pc, $past(up_pc))
        |-> lk_taken);

    // R5
    two_nt_predicts_nt_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2) && $past(up_valid && !up_taken, 2) && $past(up_valid && !up_taken)
        && same_entry($past(up_pc, 2), $past(up_pc)) && same_entry(lk_pc, $past(up_pc))
        |-> !lk_taken);

    // R9
    idle_keeps_prediction_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd1) && !$past(up_valid) && (lk_pc == $past(lk_pc))
        |-> lk_taken == $past(lk_taken));

    generate
        if (HIST_BITS != 1) begin : g_hyst_chk
            // R6
            strong_survives_one_miss_chk: assert property (@(posedge clk) disable iff (rst)
                (since_rst == 2'd3) && $past(up_valid && up_taken, 3) && $past(up_valid && up_taken, 2)
                && $past(up_valid && !up_taken)
                && same_entry($past(up_pc, 3), $past(up_pc, 2)) && same_entry($past(up_pc, 2), $past(up_pc))
                && same_entry(lk_pc, $past(up_pc))
                |-> lk_taken);
        end
    endgenerate

endmodule

bind bp_predictor bp_predictor_chk #(
    .PC_W(PC_W),
    .ENTRIES(ENTRIES),
    .HIST_BITS(HIST_BITS)
) u_chk (.*);

// File: tb/tb_bp_predictor.sv
`timescale 1ns/1ps
module tb_bp_predictor;
    localparam int unsigned PC_W = 32;
    localparam int unsigned ENT  = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [PC_W-1:0] lk_pc = '0;
    logic            up_valid = 1'b0;
    logic [PC_W-1:0] up_pc = '0;
    logic            up_taken = 1'b0;
    logic            lt2;
    logic            lt1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bp_predictor #(.PC_W(PC_W), .ENTRIES(ENT), .HIST_BITS(2)) dut (
        .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_taken(lt2),
        .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken));

    bp_predictor #(.PC_W(PC_W), .ENTRIES(ENT), .HIST_BITS(1)) dut_one (
        .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_taken(lt1),
        .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken));

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_int(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive on the falling edge, settle 1 ns, leave outputs ready to sample.
    task automatic cyc(input logic uv, input logic [PC_W-1:0] upc, input logic ut,
                       input logic [PC_W-1:0] lpc);
        @(negedge clk);
        up_valid = uv;
        up_pc    = upc;
        up_taken = ut;
        lk_pc    = lpc;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        up_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic int idx_of(input logic [PC_W-1:0] pc);
        return int'((pc >> 2) & (ENT - 1));
    endfunction

    function automatic int next2(input int s, input logic t);
        case (s)
            0: return t ? 1 : 0;
            1: return t ? 3 : 0;
            2: return t ? 3 : 0;
            default: return t ? 3 : 2;
        endcase
    endfunction

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int m2 [ENT];
        int m1 [ENT];
        logic [31:0] lf;
        int miss2;
        int miss1;
        bit first_in;
        bit first_out;

        do_reset();

        // R1: every entry predicts not-taken after reset
        for (int i = 0; i < ENT; i++) begin
            cyc(1'b0, '0, 1'b0, PC_W'(i << 2));
            chk("R1 two-bit reset", lt2, 1'b0);
            chk("R1 one-bit reset", lt1, 1'b0);
        end

        // R4: weak NT + NT -> strong NT, then T -> weak NT (still NT)
        cyc(1'b1, 32'h10, 1'b0, 32'h10);
        cyc(1'b1, 32'h10, 1'b1, 32'h10);
        cyc(1'b0, '0, 1'b0, 32'h10);
        chk("R4 matching outcome strengthens", lt2, 1'b0);
        chk("R10 one-bit follows last outcome", lt1, 1'b1);

        // R5: weak NT + T -> strong T
        cyc(1'b1, 32'h14, 1'b1, 32'h14);
        cyc(1'b0, '0, 1'b0, 32'h14);
        chk("R5 contrary outcome to weak flips", lt2, 1'b1);

        // R6: strong T survives one NT, flips on the second
        cyc(1'b1, 32'h14, 1'b0, 32'h14);
        cyc(1'b0, '0, 1'b0, 32'h14);
        chk("R6 one miss keeps taken", lt2, 1'b1);
        chk("R10 one-bit flips on one miss", lt1, 1'b0);
        cyc(1'b1, 32'h14, 1'b0, 32'h14);
        cyc(1'b0, '0, 1'b0, 32'h14);
        chk("R6 second miss flips", lt2, 1'b0);

        // R7: same-cycle lookup returns old prediction
        cyc(1'b1, 32'h18, 1'b1, 32'h18);
        chk("R7 same-cycle old value", lt2, 1'b0);
        chk("R7 same-cycle old value one-bit", lt1, 1'b0);
        cyc(1'b0, '0, 1'b0, 32'h18);
        chk("R7 new value next cycle", lt2, 1'b1);

        // R2: aliases of entry 6 share state; entry 7 does not
        cyc(1'b0, '0, 1'b0, 32'h1B);
        chk("R2 low bits ignored", lt2, 1'b1);
        cyc(1'b0, '0, 1'b0, 32'h38);
        chk("R2 high bits ignored", lt2, 1'b1);
        cyc(1'b0, '0, 1'b0, 32'hFFFF_FF18);
        chk("R2 upper bits ignored", lt2, 1'b1);
        cyc(1'b0, '0, 1'b0, 32'h1C);
        chk("R2 neighbour entry distinct", lt2, 1'b0);

        // R8: untouched entries stay at reset
        for (int i = 0; i < 4; i++) begin
            cyc(1'b0, '0, 1'b0, PC_W'(i << 2));
            chk("R8 other entries unchanged", lt2, 1'b0);
            chk("R8 other entries unchanged one-bit", lt1, 1'b0);
        end

        // R9: updates with up_valid low are ignored
        cyc(1'b0, 32'h1C, 1'b1, 32'h1C);
        cyc(1'b0, 32'h1C, 1'b1, 32'h1C);
        cyc(1'b0, '0, 1'b0, 32'h1C);
        chk("R9 invalid update ignored", lt2, 1'b0);
        chk("R9 invalid update ignored one-bit", lt1, 1'b0);

        // R3/R10: sweep against per-entry models
        do_reset();
        for (int i = 0; i < ENT; i++) begin
            m2[i] = 1;
            m1[i] = 0;
        end
        lf = 32'h1ACE_B00C;
        for (int n = 0; n < 1200; n++) begin
            logic uv;
            logic ut;
            logic [PC_W-1:0] upc;
            logic [PC_W-1:0] lpc;
            lf  = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            uv  = lf[0] | lf[9];
            ut  = lf[5] ^ lf[17];
            upc = {lf[7:0], lf[23:0]};
            lpc = (n % 3 == 0) ? upc : {lf[15:0], lf[31:16]};
            cyc(uv, upc, ut, lpc);
            chk("R3 two-bit sweep", lt2, logic'(m2[idx_of(lpc)] >= 2));
            chk("R10 one-bit sweep", lt1, logic'(m1[idx_of(lpc)]));
            if (uv) begin
                m2[idx_of(upc)] = next2(m2[idx_of(upc)], ut);
                m1[idx_of(upc)] = int'(ut);
            end
        end

        // R11: nested loop, inner pc 0x44, outer pc 0x88
        do_reset();
        miss2 = 0;
        miss1 = 0;
        first_in = 1'b1;
        first_out = 1'b1;
        for (int o = 0; o < 10; o++) begin
            for (int k = 0; k < 20; k++) begin
                logic t;
                t = (k < 19);
                cyc(1'b1, 32'h44, t, 32'h44);
                if (!first_in) begin
                    if (lt2 != t) miss2++;
                    if (lt1 != t) miss1++;
                end
                first_in = 1'b0;
            end
            begin
                logic t;
                t = (o < 9);
                cyc(1'b1, 32'h88, t, 32'h88);
                if (!first_out) begin
                    if (lt2 != t) miss2++;
                    if (lt1 != t) miss1++;
                end
                first_out = 1'b0;
            end
        end
        cyc(1'b0, '0, 1'b0, '0);
        chk_int("R11 two-bit mispredictions", miss2, 11);
        chk_int("R11 one-bit mispredictions", miss1, 20);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule